// File: doc/BRIEF.md
# Duty-Cycled Wake-Up Message Detector

This block lets a radio receiver listen for traffic while the host processor sleeps. Once armed, it cycles on its own through three phases. In the sleep phase the receive path is off. In the settle phase the receive path is powered while the oscillator stabilises. In the listen phase the block watches the sliced bit stream and its recovered clock. Each scan is timed by an internal interval counter, with no help from the host.

A message has three parts, checked in this order:
- a mandatory header;
- an optional address;
- an optional data field of up to 32 bits.

The header and address are compared bit by bit. A wrong bit ends the window at once. When the whole message has been received, the data field is stored in a readable register and a wake-up interrupt is raised. Scanning then stops until the host acknowledges. If a window closes before a complete message arrives, the block goes back to sleep and scans again on the next interval. All configuration arrives on parallel inputs.

Top module: `wakeup_scanner`

## Requirements
- R1: After reset `rx_power` and `wake_irq` are 0 and `data_out` is 0. While `arm` is 0 no scan runs. Lowering `arm` during a scan turns the receive path off on the next cycle.
- R2: Each sleep phase keeps `rx_power` low for exactly `sleep_cycles`+1 clock cycles before the next settle phase.
- R3: Each scan holds `rx_power` high for `settle_cycles`+1 settle cycles and then up to `window_cycles`+1 listen cycles. Bits are taken only in the listen phase, on a rising edge of `rx_clk`, with `rx_bit` read in the same cycle.
- R4: The header is the low `hdr_len` bits (1 to 16) of `hdr_pattern`, received most significant bit first. A mismatching header bit ends the scan, and `rx_power` falls in the cycle after that bit is sampled.
- R5: With `addr_len` = 0 no address is checked. Otherwise the low `addr_len` bits of `addr_pattern` must follow the header, most significant bit first. A mismatching address bit ends the scan the same way as a mismatching header bit.
- R6: The data field is `data_len` bits (1 to 32) following the header and any address. It is stored right-aligned in `data_out`: the first bit received lands in bit `data_len`-1, and all higher bits are 0.
- R7: With `data_len` = 0 a matched header and address raise the interrupt, and `data_out` keeps its previous value.
- R8: `wake_irq` rises after the clock edge that samples the last bit of a complete message, and `rx_power` falls at the same edge. Both stay in that state until an acknowledge arrives.
- R9: An `ack` pulse while `wake_irq` is high clears `wake_irq` on the next cycle. Scanning then restarts with a full sleep phase.
- R10: A listen window that ends without a complete message returns the block to sleep with no interrupt and no change to `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enables autonomous scanning |
| sleep_cycles | input | 16 | Sleep phase length minus one |
| settle_cycles | input | 16 | Settle phase length minus one |
| window_cycles | input | 16 | Listen window length minus one |
| hdr_pattern | input | 16 | Expected header, right-aligned |
| hdr_len | input | 5 | Header length in bits, 1 to 16 |
| addr_pattern | input | 16 | Expected address, right-aligned |
| addr_len | input | 5 | Address length in bits, 0 disables |
| data_len | input | 6 | Data field length, 0 to 32 |
| rx_bit | input | 1 | Sliced received bit |
| rx_clk | input | 1 | Recovered bit clock |
| ack | input | 1 | Host acknowledge, clears the interrupt |
| rx_power | output | 1 | Receive path enable (settle and listen) |
| wake_irq | output | 1 | Wake-up interrupt, held until acknowledged |
| data_out | output | 32 | Captured data field |

## Verification
Idle scans measure how long each phase lasts, which separates the sleep, settle and listen timers and shows whether each is off by one. Complete messages are sent with several field layouts:
- header, address and data;
- no address;
- no data;
- a full 16-bit header with a short data field;
- a full 32-bit data field.

These layouts tell apart errors in how one field hands over to the next, and errors in data alignment. Three failing patterns close the set: a wrong header bit, a wrong address bit, and a header with nothing after it. The first two must abort the scan immediately, while the third must wait for the window to expire, so each tests a different exit path. Every interrupt is matched in order against the data value the driver expected for that message.

// File: rtl/wus_pkg.sv
package wus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLEEP,
    ST_SETTLE,
    ST_LISTEN,
    ST_WAKE
  } scan_st_e;

  typedef enum logic [1:0] {
    FLD_HDR,
    FLD_ADDR,
    FLD_DATA
  } fld_e;
endpackage

// File: rtl/wus_phase_timer.sv
module wus_phase_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] value,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = value;
    else if (cnt_q != '0)  cnt_d = cnt_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(value));
endmodule

// File: rtl/wus_edge_det.sv
module wus_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/wus_field_seq.sv
module wus_field_seq
  import wus_pkg::*;
#(
  parameter int MATCH_MAX = 16,
  parameter int DATA_MAX  = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           bit_en,
  input  logic                           bit_val,
  input  logic [MATCH_MAX-1:0]           hdr_pattern,
  input  logic [$clog2(MATCH_MAX+1)-1:0] hdr_len,
  input  logic [MATCH_MAX-1:0]           addr_pattern,
  input  logic [$clog2(MATCH_MAX+1)-1:0] addr_len,
  input  logic [$clog2(DATA_MAX+1)-1:0]  data_len,
  output logic                           bad,
  output logic                           done,
  output logic                           capture,
  output logic [DATA_MAX-1:0]            data_word
);
  localparam int LEN_W  = $clog2(MATCH_MAX + 1);
  localparam int IDX_W  = $clog2(MATCH_MAX);
  localparam int DLEN_W = $clog2(DATA_MAX + 1);
  localparam int IW     = (DLEN_W > LEN_W) ? DLEN_W : LEN_W;

  fld_e                fld_q, fld_d, fld_nxt;
  logic [IW-1:0]       idx_q, idx_d, cur_len;
  logic [DATA_MAX-2:0] shr_q, shr_d;
  logic [DATA_MAX-1:0] shift_nxt;
  logic [IDX_W-1:0]    pos;
  logic                exp_bit, last, mismatch, fin;

  always_comb begin
    case (fld_q)
      FLD_HDR:  cur_len = IW'(hdr_len);
      FLD_ADDR: cur_len = IW'(addr_len);
      default:  cur_len = IW'(data_len);
    endcase
    pos       = IDX_W'(cur_len - idx_q - IW'(1));
    exp_bit   = (fld_q == FLD_HDR) ? hdr_pattern[pos] : addr_pattern[pos];
    last      = (idx_q == cur_len - IW'(1));
    mismatch  = (fld_q != FLD_DATA) && (bit_val != exp_bit);
    shift_nxt = {shr_q, bit_val};

    fld_nxt = FLD_DATA;
    fin     = 1'b0;
    case (fld_q)
      FLD_HDR: begin
        if (addr_len != '0)      fld_nxt = FLD_ADDR;
        else if (data_len != '0) fld_nxt = FLD_DATA;
        else                     fin     = 1'b1;
      end
      FLD_ADDR: begin
        if (data_len == '0) fin = 1'b1;
      end
      default: fin = 1'b1;
    endcase
  end

  assign bad       = bit_en && mismatch;
  assign done      = bit_en && !mismatch && last && fin;
  assign capture   = done && (fld_q == FLD_DATA);
  assign data_word = shift_nxt;

  always_comb begin
    fld_d = fld_q;
    idx_d = idx_q;
    shr_d = shr_q;
    if (clear) begin
      fld_d = FLD_HDR;
      idx_d = '0;
      shr_d = '0;
    end else if (bit_en && !mismatch) begin
      if (fld_q == FLD_DATA) shr_d = shift_nxt[DATA_MAX-2:0];
      if (last) begin
        idx_d = '0;
        fld_d = fld_nxt;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= FLD_HDR;
      idx_q <= '0;
      shr_q <= '0;
    end else begin
      fld_q <= fld_d;
      idx_q <= idx_d;
      shr_q <= shr_d;
    end
  end
endmodule

// File: rtl/wakeup_scanner.sv
module wakeup_scanner
  import wus_pkg::*;
#(
  parameter int TMR_W     = 16,
  parameter int MATCH_MAX = 16,
  parameter int DATA_MAX  = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           arm,
  input  logic [TMR_W-1:0]               sleep_cycles,
  input  logic [TMR_W-1:0]               settle_cycles,
  input  logic [TMR_W-1:0]               window_cycles,
  input  logic [MATCH_MAX-1:0]           hdr_pattern,
  input  logic [$clog2(MATCH_MAX+1)-1:0] hdr_len,
  input  logic [MATCH_MAX-1:0]           addr_pattern,
  input  logic [$clog2(MATCH_MAX+1)-1:0] addr_len,
  input  logic [$clog2(DATA_MAX+1)-1:0]  data_len,
  input  logic                           rx_bit,
  input  logic                           rx_clk,
  input  logic                           ack,
  output logic                           rx_power,
  output logic                           wake_irq,
  output logic [DATA_MAX-1:0]            data_out
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  scan_st_e            st_q, st_d;
  logic                tmr_load, tmr_exp, seq_clear, bit_rise, bit_en;
  logic [TMR_W-1:0]    tmr_val;
  logic                seq_bad, seq_done, seq_cap;
  logic [DATA_MAX-1:0] seq_word, data_q, data_d;

  wus_phase_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .load(tmr_load), .value(tmr_val),
    .expired(tmr_exp)
  );

  wus_edge_det u_edge (
    .clk(clk), .rst_n(rst_sync_q), .sig(rx_clk), .rise(bit_rise)
  );

  assign bit_en = bit_rise && (st_q == ST_LISTEN);

  wus_field_seq #(.MATCH_MAX(MATCH_MAX), .DATA_MAX(DATA_MAX)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .clear(seq_clear), .bit_en(bit_en),
    .bit_val(rx_bit), .hdr_pattern(hdr_pattern), .hdr_len(hdr_len),
    .addr_pattern(addr_pattern), .addr_len(addr_len), .data_len(data_len),
    .bad(seq_bad), .done(seq_done), .capture(seq_cap), .data_word(seq_word)
  );

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = sleep_cycles;
    seq_clear = 1'b0;
    case (st_q)
      ST_IDLE: if (arm) begin
        st_d     = ST_SLEEP;
        tmr_load = 1'b1;
      end
      ST_SLEEP:
        if (!arm) st_d = ST_IDLE;
        else if (tmr_exp) begin
          st_d     = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = settle_cycles;
        end
      ST_SETTLE:
        if (!arm) st_d = ST_IDLE;
        else if (tmr_exp) begin
          st_d      = ST_LISTEN;
          tmr_load  = 1'b1;
          tmr_val   = window_cycles;
          seq_clear = 1'b1;
        end
      ST_LISTEN:
        if (!arm) st_d = ST_IDLE;
        else if (seq_done) st_d = ST_WAKE;
        else if (seq_bad || tmr_exp) begin
          st_d     = ST_SLEEP;
          tmr_load = 1'b1;
        end
      ST_WAKE: if (ack) begin
        if (arm) begin
          st_d     = ST_SLEEP;
          tmr_load = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign data_d = seq_cap ? seq_word : data_q;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      data_q <= data_d;
    end
  end

  assign rx_power = (st_q == ST_SETTLE) || (st_q == ST_LISTEN);
  assign wake_irq = (st_q == ST_WAKE);
  assign data_out = data_q;

  // R8
  irq_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wake_irq |-> !rx_power);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wake_irq && !ack) |=> wake_irq);
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wake_irq && ack) |=> !wake_irq);
  // R10
  data_only_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$stable(data_out) |-> $rose(wake_irq));
  // R4
  abort_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    seq_bad |=> !rx_power);
endmodule

// File: tb/wakeup_scanner_tb.sv
`timescale 1ns/1ps
module wakeup_scanner_tb;
  localparam int SLEEP  = 5;
  localparam int SETTLE = 3;
  localparam int WINDOW = 100;

  logic        clk = 1'b0;
  logic        rst_n, arm, rx_bit, rx_clk, ack;
  logic [15:0] sleep_cycles, settle_cycles, window_cycles;
  logic [15:0] hdr_pattern, addr_pattern;
  logic [4:0]  hdr_len, addr_len;
  logic [5:0]  data_len;
  logic        rx_power, wake_irq;
  logic [31:0] data_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic finished = 1'b0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  wakeup_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sleep_cycles(sleep_cycles),
    .settle_cycles(settle_cycles), .window_cycles(window_cycles),
    .hdr_pattern(hdr_pattern), .hdr_len(hdr_len), .addr_pattern(addr_pattern),
    .addr_len(addr_len), .data_len(data_len), .rx_bit(rx_bit), .rx_clk(rx_clk),
    .ack(ack), .rx_power(rx_power), .wake_irq(wake_irq), .data_out(data_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b;
    rx_clk = 1'b1;
    @(negedge clk);
    rx_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic wait_listen();
    while (rx_power !== 1'b0) @(negedge clk);
    while (rx_power !== 1'b1) @(negedge clk);
    repeat (SETTLE + 1) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R9 irq cleared by ack", {31'd0, wake_irq}, 32'd0);
  endtask

  // Monitor: each rising interrupt pops the driver's expected data value.
  logic irq_prev = 1'b0;
  always @(negedge clk) begin
    if (wake_irq === 1'b1 && irq_prev === 1'b0) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R8 unexpected wake actual=1 expected=0");
      end else begin
        chk("R6 captured data", data_out, exp_q.pop_front());
      end
    end
    irq_prev <= wake_irq;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic seen;
    rst_n = 1'b0; arm = 1'b0; rx_bit = 1'b0; rx_clk = 1'b0; ack = 1'b0;
    sleep_cycles = 16'(SLEEP); settle_cycles = 16'(SETTLE);
    window_cycles = 16'(WINDOW);
    hdr_pattern = 16'h00A5; hdr_len = 5'd8;
    addr_pattern = 16'h003C; addr_len = 5'd8; data_len = 6'd16;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 rx_power at reset", {31'd0, rx_power}, 32'd0);
    chk("R1 irq at reset", {31'd0, wake_irq}, 32'd0);
    chk("R1 data at reset", data_out, 32'd0);
    rst_n = 1'b1;
    seen = 1'b0;
    repeat (30) begin @(negedge clk); if (rx_power) seen = 1'b1; end
    chk("R1 no scan while disarmed", {31'd0, seen}, 32'd0);

    arm = 1'b1;
    // R3 idle scan length, R2 sleep length
    while (rx_power !== 1'b1) @(negedge clk);
    cnt = 0;
    while (rx_power === 1'b1) begin cnt++; @(negedge clk); end
    chk("R3 scan high cycles", 32'(cnt), 32'(SETTLE + WINDOW + 2));
    cnt = 0;
    while (rx_power === 1'b0) begin cnt++; @(negedge clk); end
    chk("R2 sleep low cycles", 32'(cnt), 32'(SLEEP + 1));

    // R4 R5 R6 R8 full message
    wait_listen();
    exp_q.push_back(32'h0000BEEF);
    send_bits(32'hA5, 8); send_bits(32'h3C, 8); send_bits(32'hBEEF, 16);
    chk("R8 irq raised", {31'd0, wake_irq}, 32'd1);
    chk("R8 rx off on wake", {31'd0, rx_power}, 32'd0);
    seen = 1'b0;
    repeat (40) begin @(negedge clk); if (rx_power) seen = 1'b1; end
    chk("R8 irq held", {31'd0, wake_irq}, 32'd1);
    chk("R8 scanning stopped", {31'd0, seen}, 32'd0);
    do_ack();
    cnt = 0;
    while (rx_power === 1'b0) begin cnt++; @(negedge clk); end
    chk("R9 resume with sleep", 32'(cnt), 32'(SLEEP + 1));

    // R4 header mismatch aborts at once
    wait_listen();
    send_bit(1'b1);
    chk("R4 still listening after good bit", {31'd0, rx_power}, 32'd1);
    send_bit(1'b1);
    chk("R4 abort on header mismatch", {31'd0, rx_power}, 32'd0);
    chk("R4 no irq on mismatch", {31'd0, wake_irq}, 32'd0);

    // R5 address mismatch aborts
    wait_listen();
    send_bits(32'hA5, 8); send_bits(32'h0, 3);
    chk("R5 abort on address mismatch", {31'd0, rx_power}, 32'd0);

    // R10 window expiry without full message
    wait_listen();
    send_bits(32'hA5, 8);
    chk("R10 still listening", {31'd0, rx_power}, 32'd1);
    while (rx_power === 1'b1) @(negedge clk);
    chk("R10 no irq on expiry", {31'd0, wake_irq}, 32'd0);
    chk("R10 data unchanged", data_out, 32'h0000BEEF);

    // R5 no address configured, R6 12-bit data
    addr_len = 5'd0; data_len = 6'd12;
    wait_listen();
    exp_q.push_back(32'h00000ABC);
    send_bits(32'hA5, 8); send_bits(32'hABC, 12);
    chk("R5 wake without address", {31'd0, wake_irq}, 32'd1);
    do_ack();

    // R7 zero-length data keeps stored value
    addr_len = 5'd8; data_len = 6'd0;
    wait_listen();
    exp_q.push_back(32'h00000ABC);
    send_bits(32'hA5, 8); send_bits(32'h3C, 8);
    chk("R7 wake without data", {31'd0, wake_irq}, 32'd1);
    chk("R7 data kept", data_out, 32'h00000ABC);
    do_ack();

    // R6 full 32-bit data field
    addr_len = 5'd0; data_len = 6'd32;
    wait_listen();
    exp_q.push_back(32'hDEADBEEF);
    send_bits(32'hA5, 8); send_bits(32'hDEADBEEF, 32);
    chk("R6 wake 32-bit data", {31'd0, wake_irq}, 32'd1);
    do_ack();

    // R4 16-bit header, R6 4-bit data
    hdr_pattern = 16'hF00D; hdr_len = 5'd16; data_len = 6'd4;
    wait_listen();
    exp_q.push_back(32'h00000009);
    send_bits(32'hF00D, 16); send_bits(32'h9, 4);
    chk("R4 wake 16-bit header", {31'd0, wake_irq}, 32'd1);
    do_ack();

    // R1 disarm mid-scan
    while (rx_power !== 1'b1) @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
    chk("R1 disarm stops scan", {31'd0, rx_power}, 32'd0);
    seen = 1'b0;
    repeat (300) begin @(negedge clk); if (rx_power) seen = 1'b1; end
    chk("R1 stays idle", {31'd0, seen}, 32'd0);
    chk("R8 all expected wakes seen", 32'(exp_q.size()), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule